// File: doc/BRIEF.md
# Three-Source Interrupt Request Unit

This unit merges three interrupt sources onto one shared, active-low request line, in the style of a wired-OR. The first source is a time-of-day alarm. It compares the live seconds, minutes and hours fields, each as BCD, against three programmed values. The second source is a periodic tick. A 4-bit rate selector picks one of fifteen prescaler strobes, whose periods run from a fraction of a second to a full day. The third source is a supply-failure indication. It arrives as an asynchronous level, which the unit synchronizes and edge-detects.

Each source latches its own sticky flag in a status register. A host reads and writes the unit through a small register port. Reading the status register returns the flags and clears them all. The request is active while any flag that is also enabled remains set.

The line is open-drain: the unit either pulls it low or leaves it floating, and it never drives it high. The port `irq_pull` is the pull-down enable of that driver. A value of 1 means the shared line is being held low. The time base, the prescaler and the analog supply sensing are all outside this unit.

Top module: `tri_source_irq`

## Requirements
- R1: After reset, `irq_pull` is 0 and every register reads 0. An alarm match that is already present when reset is released does not set the alarm flag.
- R2: The alarm flag (status bit 0) sets only when all three fields are equal to their alarm registers: `time_sec` to address 0, `time_min` to address 1 and `time_hr` to address 2. The compare covers all 8 bits of each field. If any one field differs, the flag does not set.
- R3: The alarm flag sets once per match. If the fields stay matched after the flag has been cleared, it does not set again. A later match that follows at least one mismatching cycle sets it again.
- R4: Control bits [3:0] hold the rate selector. A value of 0 disables the periodic source. A value k from 1 to 15 sets the periodic flag (status bit 1) on a strobe of `rate_taps[k-1]` and on no other tap.
- R5: The power-fail flag (status bit 2) sets on a rising edge of `pwr_fail`. It becomes visible in the third clock cycle after the input rises, counting from the first active edge. A level held high sets it only once.
- R6: A source sets its flag whether or not that source is enabled. A status read at address 4 returns {pf, periodic, alarm} in bits [2:0] and clears all three flags.
- R7: `irq_pull` is 1 exactly when an enabled flag is set. The alarm source is enabled by control bit 4 and the power-fail source by control bit 5. The periodic source is enabled whenever its selector is non-zero. The request is released after the status read that clears the flags.
- R8: Addresses 0 to 3 read back what was written to them. Addresses 5 to 7 read 0. Writes to addresses 4 to 7 have no effect.
- R9: If a source event and a status read fall in the same cycle, the read returns the old flag value and the new event stays latched for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_sec | input | 8 | Live seconds, BCD |
| time_min | input | 8 | Live minutes, BCD |
| time_hr | input | 8 | Live hours, BCD with mode bits |
| rate_taps | input | 15 | One-cycle prescaler strobes, one per rate |
| pwr_fail | input | 1 | Asynchronous supply-failure level, high = failing |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_pull | output | 1 | Pull-down enable of the open-drain request line |

## Verification
The alarm compare is driven through all eight match/miss combinations of the three fields. This separates a full three-field compare from one that ignores a field or requires only a partial match. The rate selector is swept over all sixteen values against a strobe on each of the fifteen taps. That sweep shows an off-by-one in tap indexing, a selector of 0 that is not fully off, and leakage from taps that are not selected. Held alarm matches and held power-fail levels test the once-per-event behaviour, and cycle-exact sampling of the power-fail path checks the synchronizer depth. A source event that lands on the same cycle as a status read shows whether the set is lost to the clear.

// File: rtl/tri_source_irq_pkg.sv
package tri_source_irq_pkg;
   localparam int unsigned NUM_SRC = 3;
   localparam int unsigned ADDR_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_ALM_SEC = 3'd0,
      A_ALM_MIN = 3'd1,
      A_ALM_HR  = 3'd2,
      A_CTRL    = 3'd3,
      A_STATUS  = 3'd4
   } reg_addr_e;

   localparam int unsigned SRC_ALARM = 0;
   localparam int unsigned SRC_RATE  = 1;
   localparam int unsigned SRC_PF    = 2;
endpackage

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] now_sec,
   input  logic [FIELD_W-1:0] now_min,
   input  logic [FIELD_W-1:0] now_hr,
   input  logic [FIELD_W-1:0] set_sec,
   input  logic [FIELD_W-1:0] set_min,
   input  logic [FIELD_W-1:0] set_hr,
   output logic               hit
);
   logic match;
   logic match_q;

   assign match = (now_sec == set_sec) && (now_min == set_min) && (now_hr == set_hr);

   // starts "already matched" so a match present at reset release is not an event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b1;
      else        match_q <= match;
   end

   assign hit = match & ~match_q;
endmodule

// File: rtl/irq_rate_pick.sv
module irq_rate_pick #(
   parameter int unsigned NUM_RATES = 15,
   parameter int unsigned SEL_W     = 4
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_RATES-1:0] taps,
   output logic                 hit
);
   logic [NUM_RATES-1:0] gated;

   generate
      for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
         assign gated[i] = taps[i] & (sel == SEL_W'(i + 1));
      end
   endgenerate

   assign hit = |gated;
endmodule

// File: rtl/irq_pf_edge.sv
module irq_pf_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= level;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], level};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign hit = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tri_source_irq.sv
module tri_source_irq
   import tri_source_irq_pkg::*;
#(
   parameter int unsigned FIELD_W     = 8,
   parameter int unsigned NUM_RATES   = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FIELD_W-1:0]   time_sec,
   input  logic [FIELD_W-1:0]   time_min,
   input  logic [FIELD_W-1:0]   time_hr,
   input  logic [NUM_RATES-1:0] rate_taps,
   input  logic                 pwr_fail,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [2:0]           reg_addr,
   input  logic [FIELD_W-1:0]   reg_wdata,
   output logic [FIELD_W-1:0]   reg_rdata,
   output logic                 irq_pull
);
   localparam int unsigned SEL_W = $clog2(NUM_RATES + 1);

   generate
      if (FIELD_W < SEL_W + 2) begin : g_bad_width
         $error("FIELD_W too narrow for control register");
      end
      if (FIELD_W < NUM_SRC) begin : g_bad_status
         $error("FIELD_W too narrow for status register");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (NUM_RATES < 1) begin : g_bad_rates
         $error("NUM_RATES must be at least 1");
      end
   endgenerate

   logic [FIELD_W-1:0] alm_sec, alm_min, alm_hr;
   logic [SEL_W-1:0]   rate_sel;
   logic               alm_en, pf_en;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] src_en;
   logic               alarm_hit, rate_hit, pf_hit;
   logic               status_clr;

   irq_alarm_cmp #(.FIELD_W(FIELD_W)) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .now_sec(time_sec), .now_min(time_min), .now_hr(time_hr),
      .set_sec(alm_sec), .set_min(alm_min), .set_hr(alm_hr),
      .hit(alarm_hit)
   );

   irq_rate_pick #(.NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_rate (
      .sel(rate_sel), .taps(rate_taps), .hit(rate_hit)
   );

   irq_pf_edge #(.STAGES(SYNC_STAGES)) u_pf (
      .clk(clk), .rst_n(rst_n), .level(pwr_fail), .hit(pf_hit)
   );

   // host writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_sec  <= '0;
         alm_min  <= '0;
         alm_hr   <= '0;
         rate_sel <= '0;
         alm_en   <= 1'b0;
         pf_en    <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_ALM_SEC: alm_sec <= reg_wdata;
            A_ALM_MIN: alm_min <= reg_wdata;
            A_ALM_HR:  alm_hr  <= reg_wdata;
            A_CTRL: begin
               rate_sel <= reg_wdata[SEL_W-1:0];
               alm_en   <= reg_wdata[SEL_W];
               pf_en    <= reg_wdata[SEL_W+1];
            end
            default: ;
         endcase
      end
   end

   assign status_clr = reg_rd && (reg_addr == A_STATUS);

   // sticky flags: a new event outranks the clear
   logic [NUM_SRC-1:0] src_hit;
   assign src_hit[SRC_ALARM] = alarm_hit;
   assign src_hit[SRC_RATE]  = rate_hit;
   assign src_hit[SRC_PF]    = pf_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= src_hit | (flags & {NUM_SRC{~status_clr}});
   end

   assign src_en[SRC_ALARM] = alm_en;
   assign src_en[SRC_RATE]  = (rate_sel != '0);
   assign src_en[SRC_PF]    = pf_en;

   assign irq_pull = |(flags & src_en);

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_ALM_SEC: reg_rdata = alm_sec;
         A_ALM_MIN: reg_rdata = alm_min;
         A_ALM_HR:  reg_rdata = alm_hr;
         A_CTRL: begin
            reg_rdata[SEL_W-1:0] = rate_sel;
            reg_rdata[SEL_W]     = alm_en;
            reg_rdata[SEL_W+1]   = pf_en;
         end
         A_STATUS:  reg_rdata[NUM_SRC-1:0] = flags;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tri_source_irq_chk.sv
module tri_source_irq_chk #(
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned SEL_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [FIELD_W-1:0] time_sec,
   input logic [FIELD_W-1:0] time_min,
   input logic [FIELD_W-1:0] time_hr,
   input logic [FIELD_W-1:0] alm_sec,
   input logic [FIELD_W-1:0] alm_min,
   input logic [FIELD_W-1:0] alm_hr,
   input logic [2:0]         flags,
   input logic               alarm_hit,
   input logic               rate_hit,
   input logic               pf_hit,
   input logic [SEL_W-1:0]   rate_sel,
   input logic               reg_rd,
   input logic               reg_wr,
   input logic [2:0]         reg_addr,
   input logic               irq_pull
);
   // R2
   alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(time_sec == alm_sec && time_min == alm_min && time_hr == alm_hr));

   // R3
   alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> !alarm_hit);

   // R4
   rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |-> !rate_hit);

   // R5
   pf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_hit |=> !pf_hit);

   // R6
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd4 && !alarm_hit && !rate_hit && !pf_hit) |=> (flags == 3'b000));

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pull) |-> $past(alarm_hit || rate_hit || pf_hit || reg_wr));
endmodule

bind tri_source_irq tri_source_irq_chk #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tri_source_irq_bench.sv
`timescale 1ns/1ps
module tri_source_irq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  time_sec = 8'h00, time_min = 8'h00, time_hr = 8'h00;
   logic [14:0] rate_taps = '0;
   logic        pwr_fail = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        irq_pull;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tri_source_irq u_tri_source_irq (
      .clk(clk), .rst_n(rst_n),
      .time_sec(time_sec), .time_min(time_min), .time_hr(time_hr),
      .rate_taps(rate_taps), .pwr_fail(pwr_fail),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pull(irq_pull)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
      @(negedge clk);
      time_sec = s; time_min = m; time_hr = h;
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, time 00:00:00 equals reset alarm values
      check("R1 irq", {7'd0, irq_pull}, 8'h00);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 reg", d, 8'h00);
      end

      // R8 readback and ignored writes
      wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
      wr(3'd3, 8'h00);
      wr(3'd5, 8'hFF); wr(3'd4, 8'hFF);
      rd(3'd0, d); check("R8 alm sec", d, 8'h56);
      rd(3'd1, d); check("R8 alm min", d, 8'h34);
      rd(3'd2, d); check("R8 alm hr", d, 8'h12);
      rd(3'd5, d); check("R8 addr5", d, 8'h00);
      rd(3'd4, d); check("R8 status untouched", d, 8'h00);
      rd(3'd3, d); check("R8 ctrl", d, 8'h00);

      // R2 all match/miss combinations; alarm disabled so also R6 sticky
      for (int c = 0; c < 8; c++) begin
         set_time(8'h57, 8'h35, 8'h92);
         set_time(c[0] ? 8'h56 : 8'h57, c[1] ? 8'h34 : 8'h35, c[2] ? 8'h12 : 8'h92);
         @(negedge clk);
         check("R7 disabled alarm no irq", {7'd0, irq_pull}, 8'h00);
         rd(3'd4, d);
         check("R2 R6 alarm combo", d, (c == 7) ? 8'h01 : 8'h00);
      end

      // R3 held match does not re-fire; alarm enabled for R7
      wr(3'd3, 8'h10);
      set_time(8'h57, 8'h34, 8'h12);
      set_time(8'h56, 8'h34, 8'h12);
      @(negedge clk);
      check("R7 alarm irq", {7'd0, irq_pull}, 8'h01);
      rd(3'd4, d); check("R3 first match", d, 8'h01);
      check("R7 released", {7'd0, irq_pull}, 8'h00);
      repeat (5) @(negedge clk);
      rd(3'd4, d); check("R3 held match", d, 8'h00);
      set_time(8'h00, 8'h34, 8'h12);
      set_time(8'h56, 8'h34, 8'h12);
      @(negedge clk);
      rd(3'd4, d); check("R3 rematch", d, 8'h01);
      set_time(8'h00, 8'h00, 8'h00);

      // R4 selector sweep
      for (int s = 0; s < 16; s++) begin
         wr(3'd3, 8'(s));
         for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            rate_taps = 15'(1 << k);
            @(negedge clk);
            rate_taps = '0;
            check("R4 R7 rate irq", {7'd0, irq_pull}, (s == k + 1) ? 8'h01 : 8'h00);
            rd(3'd4, d);
            check("R4 rate flag", d, (s == k + 1) ? 8'h02 : 8'h00);
         end
      end

      // R9 event in the same cycle as the status read
      wr(3'd3, 8'h03);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'd4; rate_taps = 15'h0004;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; rate_taps = '0;
      check("R9 old value", d, 8'h00);
      rd(3'd4, d); check("R9 kept event", d, 8'h02);

      // R5 power-fail timing and once-per-edge
      wr(3'd3, 8'h20);
      @(negedge clk);
      pwr_fail = 1'b1;
      @(negedge clk);
      check("R5 edge1", {7'd0, irq_pull}, 8'h00);
      @(negedge clk);
      check("R5 edge2", {7'd0, irq_pull}, 8'h00);
      @(negedge clk);
      check("R5 R7 edge3", {7'd0, irq_pull}, 8'h01);
      rd(3'd4, d); check("R5 pf flag", d, 8'h04);
      repeat (6) @(negedge clk);
      rd(3'd4, d); check("R5 held level", d, 8'h00);
      pwr_fail = 1'b0;
      repeat (4) @(negedge clk);
      pwr_fail = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd4, d); check("R5 second edge", d, 8'h04);

      // R6 pf with enable off still latches; R7 no request
      wr(3'd3, 8'h00);
      pwr_fail = 1'b0;
      repeat (4) @(negedge clk);
      pwr_fail = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 R7 masked pf", {7'd0, irq_pull}, 8'h00);
      rd(3'd4, d); check("R6 masked pf flag", d, 8'h04);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule